// File: doc/BRIEF.md
# Phase-Slip Horizontal Ball Positioner

This block places a ball on each raster line without storing a coordinate. A 9-bit counter runs only while the line is in its active region. Its period matches the 374 active columns of a line, so while that holds, the column where it passes the top four values stays fixed from line to line. To move the ball, the value the counter reloads after its wrap is changed by one. The next pass then arrives one column earlier or later, and the ball shifts one pixel.

Direction is held in a single flag. A paddle hit sets it, and in attract mode it flips at the screen edges. A saturating hit counter sets how many lines of each field are allowed to slip. The first one, two or three lines after vertical blanking carry the move strobe, so the ball speeds up as the rally grows. A scored point clears the hit counter.

Top module: `hball_phase_top`

## Requirements
- R1: The 9-bit position counter changes only on clocks where `hactive_i` is high; otherwise it holds its value.
- R2: On an enabled clock with the counter at 511 and `move_o` low, it reloads 138 (period 374). The ball's column then repeats on every line.
- R3: On an enabled clock at 511 with `move_o` high and `dir_right_o` = 1, it reloads 137 (period 375). The ball appears one column further right on the next line.
- R4: On an enabled clock at 511 with `move_o` high and `dir_right_o` = 0, it reloads 139 (period 373). The ball appears one column further left.
- R5: `ball_vis_o` is high exactly while the counter holds 508, 509, 510 or 511, which makes the ball four active columns wide.
- R6: `hit_left_i` sets `dir_right_o` to 1 on the next clock. `hit_right_i` alone sets it to 0. If both are high, `hit_left_i` wins. Repeated hits leave the direction unchanged.
- R7: With `attract_i` high and no hit, `edge_i` inverts `dir_right_o` on the next clock. With `attract_i` low, `edge_i` has no effect.
- R8: The hit counter adds one per clock with either hit input high and stops at 12. `point_i` clears it to 0 and takes priority over a hit in the same clock.
- R9: `vblank_i` high forces `move_o` low on the next clock and restarts the line count. Each `line_start_i` outside blanking sets `move_o` for that line if fewer than N lines have passed since blanking. N is 1 for hit counts 0–3, 2 for 4–11 and 3 for 12.
- R10: After reset the counter is at 320, `dir_right_o` = 1, the hit count is 0 and `move_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hactive_i | input | 1 | High during the active (non-blanked) part of a line |
| line_start_i | input | 1 | One-clock pulse at the start of each line |
| vblank_i | input | 1 | High during vertical blanking |
| hit_left_i | input | 1 | Ball touched the left paddle |
| hit_right_i | input | 1 | Ball touched the right paddle |
| attract_i | input | 1 | Attract (demo) mode |
| edge_i | input | 1 | Ball left the screen horizontally |
| point_i | input | 1 | A point was scored; clears the hit count |
| ball_vis_o | output | 1 | Ball occupies the current column |
| dir_right_o | output | 1 | 1 = ball travels right, 0 = left |
| move_o | output | 1 | Current line is a slip (move) line |

## Verification
The bench measures the ball's starting column on every line and checks that it stays fixed between move lines. Across a field it must shift by exactly plus or minus the number of move lines. Swapped reload values would send the ball the wrong way, and a wrong nominal value would make it drift on every line. The hit count is driven past 12 to catch a counter that wraps instead of saturating, which would drop the speed back to one move line. Edge pulses are given both with and without attract mode, and a scored point is given after a long rally, so that a stuck direction or an uncleared speed tier shows up as a wrong column delta.

// File: rtl/hball_pkg.sv
package hball_pkg;
  typedef enum logic {DIR_LEFT = 1'b0, DIR_RIGHT = 1'b1} dir_e;

  // number of slip lines per field for a given hit count
  function automatic logic [1:0] slip_lines(input logic [3:0] hits,
                                            input logic [3:0] tier1,
                                            input logic [3:0] tier2);
    if (hits >= tier2)      return 2'd3;
    else if (hits >= tier1) return 2'd2;
    else                    return 2'd1;
  endfunction
endpackage

// File: rtl/hball_phase_ctr.sv
module hball_phase_ctr #(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned START      = 320,
  parameter int unsigned LOAD_STAY  = 138,
  parameter int unsigned LOAD_LEFT  = 139,
  parameter int unsigned LOAD_RIGHT = 137,
  parameter int unsigned VIS_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             move_i,
  input  logic             dir_right_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             vis_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] VIS_LO  = CNT_MAX - CNT_W'(VIS_W - 1);

  logic [CNT_W-1:0] pos_q, reload;

  always_comb begin
    if (!move_i)          reload = CNT_W'(LOAD_STAY);
    else if (dir_right_i) reload = CNT_W'(LOAD_RIGHT);
    else                  reload = CNT_W'(LOAD_LEFT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pos_q <= CNT_W'(START);
    else if (en_i) begin
      if (pos_q == CNT_MAX)   pos_q <= reload;
      else                    pos_q <= pos_q + 1'b1;
    end
  end

  assign pos_o = pos_q;
  assign vis_o = (pos_q >= VIS_LO);
endmodule

// File: rtl/hball_dir.sv
module hball_dir
  import hball_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_left_i,
  input  logic hit_right_i,
  input  logic attract_i,
  input  logic edge_i,
  output logic dir_right_o
);
  dir_e dir_q;

  // hits force a side; walls only bounce in attract mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   dir_q <= DIR_RIGHT;
    else if (hit_left_i)           dir_q <= DIR_RIGHT;
    else if (hit_right_i)          dir_q <= DIR_LEFT;
    else if (attract_i && edge_i)  dir_q <= (dir_q == DIR_RIGHT) ? DIR_LEFT : DIR_RIGHT;
  end

  assign dir_right_o = (dir_q == DIR_RIGHT);
endmodule

// File: rtl/hball_speed.sv
module hball_speed
  import hball_pkg::*;
#(
  parameter int unsigned HIT_W   = 4,
  parameter int unsigned HIT_CAP = 12,
  parameter int unsigned TIER1   = 4,
  parameter int unsigned TIER2   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             point_i,
  input  logic             vblank_i,
  input  logic             line_start_i,
  output logic [HIT_W-1:0] hits_o,
  output logic             move_o
);
  localparam logic [HIT_W-1:0] CAP = HIT_W'(HIT_CAP);

  logic [HIT_W-1:0] hits_q;
  logic [1:0]       line_q, n_slip;
  logic             move_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hits_q <= '0;
    else if (point_i)               hits_q <= '0;
    else if (hit_i && hits_q < CAP) hits_q <= hits_q + 1'b1;
  end

  assign n_slip = slip_lines(4'(hits_q), 4'(TIER1), 4'(TIER2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      move_q <= 1'b0;
    end else if (vblank_i) begin
      line_q <= '0;
      move_q <= 1'b0;
    end else if (line_start_i) begin
      move_q <= (line_q < n_slip);
      if (line_q != 2'd3) line_q <= line_q + 1'b1;
    end
  end

  assign hits_o = hits_q;
  assign move_o = move_q;
endmodule

// File: rtl/hball_phase_top.sv
module hball_phase_top #(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned START      = 320,
  parameter int unsigned LOAD_STAY  = 138,
  parameter int unsigned LOAD_LEFT  = 139,
  parameter int unsigned LOAD_RIGHT = 137,
  parameter int unsigned VIS_W      = 4,
  parameter int unsigned HIT_W      = 4,
  parameter int unsigned HIT_CAP    = 12,
  parameter int unsigned TIER1      = 4,
  parameter int unsigned TIER2      = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hactive_i,
  input  logic line_start_i,
  input  logic vblank_i,
  input  logic hit_left_i,
  input  logic hit_right_i,
  input  logic attract_i,
  input  logic edge_i,
  input  logic point_i,
  output logic ball_vis_o,
  output logic dir_right_o,
  output logic move_o
);
  logic [CNT_W-1:0] pos_q;
  logic [HIT_W-1:0] hits_q;

  hball_speed #(
    .HIT_W(HIT_W), .HIT_CAP(HIT_CAP), .TIER1(TIER1), .TIER2(TIER2)
  ) u_speed (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hit_i(hit_left_i | hit_right_i), .point_i(point_i),
    .vblank_i(vblank_i), .line_start_i(line_start_i),
    .hits_o(hits_q), .move_o(move_o)
  );

  hball_dir u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hit_left_i(hit_left_i), .hit_right_i(hit_right_i),
    .attract_i(attract_i), .edge_i(edge_i),
    .dir_right_o(dir_right_o)
  );

  hball_phase_ctr #(
    .CNT_W(CNT_W), .START(START), .LOAD_STAY(LOAD_STAY),
    .LOAD_LEFT(LOAD_LEFT), .LOAD_RIGHT(LOAD_RIGHT), .VIS_W(VIS_W)
  ) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(hactive_i),
    .move_i(move_o), .dir_right_i(dir_right_o),
    .pos_o(pos_q), .vis_o(ball_vis_o)
  );
endmodule

// File: rtl/hball_phase_chk.sv
module hball_phase_chk #(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned LOAD_STAY  = 138,
  parameter int unsigned LOAD_LEFT  = 139,
  parameter int unsigned LOAD_RIGHT = 137,
  parameter int unsigned HIT_W      = 4,
  parameter int unsigned HIT_CAP    = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hactive_i,
  input logic             vblank_i,
  input logic             hit_left_i,
  input logic             hit_right_i,
  input logic             attract_i,
  input logic             edge_i,
  input logic             point_i,
  input logic [CNT_W-1:0] pos_i,
  input logic [HIT_W-1:0] hits_i,
  input logic             move_o,
  input logic             dir_right_o,
  input logic             ball_vis_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r1_hold_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hactive_i |=> $stable(pos_i));
  a_r2_reload_stay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hactive_i && pos_i == CNT_MAX && !move_o |=> pos_i == CNT_W'(LOAD_STAY));
  a_r3_reload_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hactive_i && pos_i == CNT_MAX && move_o && dir_right_o |=> pos_i == CNT_W'(LOAD_RIGHT));
  a_r4_reload_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hactive_i && pos_i == CNT_MAX && move_o && !dir_right_o |=> pos_i == CNT_W'(LOAD_LEFT));
  a_r5_vis_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hactive_i && ball_vis_o && pos_i != CNT_MAX |=> ball_vis_o);
  a_r6_left_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_left_i |=> dir_right_o);
  a_r6_right_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_right_i && !hit_left_i |=> !dir_right_o);
  a_r7_wall_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attract_i && edge_i && !hit_left_i && !hit_right_i |=> dir_right_o != $past(dir_right_o));
  a_r8_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hits_i <= HIT_W'(HIT_CAP));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    point_i |=> hits_i == '0);
  a_r9_blank_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i |=> !move_o);
endmodule

bind hball_phase_top hball_phase_chk #(
  .CNT_W(CNT_W), .LOAD_STAY(LOAD_STAY), .LOAD_LEFT(LOAD_LEFT),
  .LOAD_RIGHT(LOAD_RIGHT), .HIT_W(HIT_W), .HIT_CAP(HIT_CAP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hactive_i(hactive_i), .vblank_i(vblank_i),
  .hit_left_i(hit_left_i), .hit_right_i(hit_right_i), .attract_i(attract_i),
  .edge_i(edge_i), .point_i(point_i), .pos_i(pos_q), .hits_i(hits_q),
  .move_o(move_o), .dir_right_o(dir_right_o), .ball_vis_o(ball_vis_o)
);

// File: tb/sim_hball_phase_top.sv
`timescale 1ns/1ps
module sim_hball_phase_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hactive = 0, line_start = 0, vblank = 1, hl = 0, hr = 0, attract = 0, edg = 0, point = 0;
  logic ball_vis, dir_right, move;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hball_phase_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .hactive_i(hactive), .line_start_i(line_start),
    .vblank_i(vblank), .hit_left_i(hl), .hit_right_i(hr), .attract_i(attract),
    .edge_i(edg), .point_i(point), .ball_vis_o(ball_vis), .dir_right_o(dir_right),
    .move_o(move)
  );

  // behavioural reference
  int m_cnt, m_dir, m_hits, m_line, m_move;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 320; m_dir = 1; m_hits = 0; m_line = 0; m_move = 0;
    end else begin
      int n, c, d, h, l, mv;
      n = (m_hits >= 12) ? 3 : (m_hits >= 4) ? 2 : 1;
      c = m_cnt; d = m_dir; h = m_hits; l = m_line; mv = m_move;
      if (hactive) c = (m_cnt == 511) ? (m_move ? (m_dir ? 137 : 139) : 138) : m_cnt + 1;
      if (hl) d = 1; else if (hr) d = 0; else if (attract && edg) d = 1 - m_dir;
      if (point) h = 0; else if ((hl || hr) && m_hits < 12) h = m_hits + 1;
      if (vblank) begin l = 0; mv = 0; end
      else if (line_start) begin mv = (m_line < n) ? 1 : 0; l = (m_line < 3) ? m_line + 1 : 3; end
      m_cnt = c; m_dir = d; m_hits = h; m_line = l; m_move = mv;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare against model every cycle (at negedge)
  task automatic cmp_model();
    chk(ball_vis == (m_cnt >= 508), "R5 visibility", ball_vis, m_cnt >= 508);
    chk(dir_right == m_dir[0], "R6 direction", dir_right, m_dir);
    chk(move == m_move[0], "R9 move strobe", move, m_move);
  endtask

  int line_col, line_w;
  task automatic run_line(input bit vb);
    line_col = -1; line_w = 0;
    for (int c = 0; c < 455; c++) begin
      @(negedge clk);
      cmp_model();
      if (hactive && ball_vis) begin
        if (line_col < 0) line_col = c - 1;
        line_w++;
      end
      line_start = (c == 0);
      hactive = (c >= 81);
      vblank = vb;
    end
  endtask

  int f_moves, f_col, f_prev_col, f_w;
  task automatic run_field();
    int cols[$];
    f_moves = 0;
    for (int i = 0; i < 3; i++) run_line(1);
    for (int i = 0; i < 8; i++) begin
      run_line(0);
      if (move) f_moves++;   // move_o of the line just finished is still held
      cols.push_back(line_col);
    end
    f_w = line_w;
    f_col = cols[$];
    chk(cols[7] == cols[6] && cols[6] == cols[5], "R2 column steady", cols[6], cols[7]);
  endtask

  task automatic step(input bit l, input bit r, input bit a, input bit e, input bit p);
    @(negedge clk);
    cmp_model();
    line_start = 0; hactive = 0; vblank = 1;
    hl = l; hr = r; attract = a; edg = e; point = p;
    @(negedge clk);
    hl = 0; hr = 0; edg = 0; point = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(dir_right == 1'b1, "R10 reset dir", dir_right, 1);
    chk(move == 1'b0, "R10 reset move", move, 0);
    chk(ball_vis == 1'b0, "R10 reset vis", ball_vis, 0);

    run_field();
    chk(f_moves == 1, "R9 one slip line at 0 hits", f_moves, 1);
    chk(f_w == 4, "R5 ball width", f_w, 4);
    f_prev_col = f_col;
    run_field();
    chk(f_col - f_prev_col == 1, "R3 right slip", f_col - f_prev_col, 1);
    f_prev_col = f_col;

    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0);
    chk(dir_right == 1'b0, "R6 right paddle sends left", dir_right, 0);
    run_field();
    chk(f_moves == 2, "R9 two slip lines at 4 hits", f_moves, 2);
    chk(f_col - f_prev_col == -2, "R4 left slip", f_col - f_prev_col, -2);
    f_prev_col = f_col;

    for (int i = 0; i < 13; i++) step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    chk(dir_right == 1'b1, "R6 left paddle wins", dir_right, 1);
    run_field();
    chk(f_moves == 3, "R8 saturated at 12", f_moves, 3);
    chk(f_col - f_prev_col == 3, "R3 three right slips", f_col - f_prev_col, 3);
    f_prev_col = f_col;

    step(0, 0, 0, 1, 0);
    chk(dir_right == 1'b1, "R7 edge ignored outside attract", dir_right, 1);
    step(0, 0, 1, 1, 0);
    chk(dir_right == 1'b0, "R7 attract wall bounce", dir_right, 0);
    run_field();
    chk(f_col - f_prev_col == -3, "R7 bounce then left slips", f_col - f_prev_col, -3);
    f_prev_col = f_col;

    // hold-off check: frozen counter while blank (R1)
    for (int i = 0; i < 50; i++) step(0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 1);
    run_field();
    chk(f_moves == 1, "R8 point clears hits", f_moves, 1);
    chk(f_col - f_prev_col == 1, "R1 hold while blank, one right slip", f_col - f_prev_col, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule